// File: doc/BRIEF.md
# Scroll and Address Register Port with Shared Write Toggle

This block is the processor-side register logic of a tile-based video controller. An 8-bit bus delivers one byte per write to one of two ports: a scroll port and an address port. A full 15-bit video memory address takes more than one byte. A single toggle flag therefore records whether the next byte is the first or the second of a pair. Both ports use this same flag, so a sequence that mixes the two ports picks up from whatever state the flag holds.

Each byte first updates a 15-bit staging register. The live address register is loaded from the staging register only when the address port receives its second byte. A 3-bit fine horizontal scroll value is captured separately. A read of the status register clears the toggle, which gives software a known starting point before a pair of writes. The block drives the live address, the staging register, the fine scroll value and the toggle state.

Top module: `vreg_port`

## Requirements
- R1: While `rst` is high at a rising clock edge, the live address, the staging register, `fine_x` and `toggle` all become zero.
- R2: Port selection is `wr_sel` = 0 for the scroll port and `wr_sel` = 1 for the address port. Both ports share one toggle, and every accepted write to either port inverts it.
- R3: When `status_rd` is high at a clock edge, `toggle` is cleared. The next accepted write to either port is then handled as a first write.
- R4: A scroll write with `toggle` = 0 loads staging bits [4:0] from data[7:3] and loads `fine_x` from data[2:0]. All other staging bits keep their values.
- R5: A scroll write with `toggle` = 1 loads staging bits [14:12] from data[2:0] and staging bits [9:5] from data[7:3]. All other staging bits, and `fine_x`, keep their values.
- R6: An address write with `toggle` = 0 loads staging bits [13:8] from data[5:0] and clears staging bit 14. Data bits [7:6] are ignored, and staging bits [7:0] are kept.
- R7: An address write with `toggle` = 1 loads staging bits [7:0] from the data byte. On the same edge, the live address takes the complete new staging value.
- R8: The live address changes only on the event in R7 or on reset. `fine_x` changes only on the event in R4 or on reset.
- R9: If `status_rd` and `wr_en` are both high in the same cycle, the write is discarded. Only the toggle clear takes effect.
- R10: All outputs come from registers. A write sampled at a rising edge appears on the outputs right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A byte write is present this cycle |
| wr_sel | input | 1 | Target port: 0 = scroll, 1 = address |
| wr_data | input | 8 | Written byte |
| status_rd | input | 1 | Status register is read this cycle (clears the toggle) |
| vaddr_cur | output | 15 | Live video memory address |
| vaddr_tmp | output | 15 | Staging address register |
| fine_x | output | 3 | Fine horizontal scroll |
| toggle | output | 1 | Shared write toggle (1 = next byte is the second of a pair) |

## Verification
A status read and a port write can arrive in the same cycle. The status read clears the toggle, while the write would normally invert the toggle and modify the staging state. The bench first leaves the toggle in a known state. It then raises `status_rd` and `wr_en` together with a data byte that would change several staging bits and `fine_x`. The result passes only if the toggle reads zero after that edge, the staging register, the live address and `fine_x` are unchanged, and the next scroll write is handled as a first write.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 15;
    localparam int FX_W     = 3;
    localparam int COARSE_W = 5;
    localparam int FY_W     = 3;
    localparam int HI_W     = 6;
    localparam int LO_W     = 8;

    // Field positions inside the staging register
    localparam int CX_LSB   = 0;
    localparam int CY_LSB   = COARSE_W;
    localparam int HI_LSB   = LO_W;
    localparam int FY_LSB   = ADDR_W - FY_W;
    localparam int TOP_BIT  = ADDR_W - 1;

    typedef enum logic {
        PORT_SCROLL = 1'b0,
        PORT_ADDR   = 1'b1
    } port_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_SCROLL_1ST,
        WK_SCROLL_2ND,
        WK_ADDR_1ST,
        WK_ADDR_2ND
    } wkind_e;

    typedef struct packed {
        logic              en;
        port_e             sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] tmp;
        logic [FX_W-1:0]   fx;
        logic              commit;
    } upd_t;

    function automatic upd_t apply_write(
        input wkind_e            kind,
        input logic [ADDR_W-1:0] tmp,
        input logic [FX_W-1:0]   fx,
        input logic [DATA_W-1:0] d
    );
        upd_t u;
        u.tmp    = tmp;
        u.fx     = fx;
        u.commit = 1'b0;
        case (kind)
            WK_SCROLL_1ST: begin
                u.tmp[CX_LSB +: COARSE_W] = d[DATA_W-1 -: COARSE_W];
                u.fx                      = d[FX_W-1:0];
            end
            WK_SCROLL_2ND: begin
                u.tmp[FY_LSB +: FY_W]     = d[FY_W-1:0];
                u.tmp[CY_LSB +: COARSE_W] = d[DATA_W-1 -: COARSE_W];
            end
            WK_ADDR_1ST: begin
                u.tmp[HI_LSB +: HI_W] = d[HI_W-1:0];
                u.tmp[TOP_BIT]        = 1'b0;
            end
            WK_ADDR_2ND: begin
                u.tmp[LO_W-1:0] = d[LO_W-1:0];
                u.commit        = 1'b1;
            end
            default: ;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
    import vreg_pkg::*;
(
    input  wr_req_t req,
    input  logic    status_rd,
    input  logic    toggle,
    output wkind_e  kind
);
    always_comb begin
        kind = WK_NONE;
        if (req.en && !status_rd) begin
            case ({req.sel, toggle})
                {PORT_SCROLL, 1'b0}: kind = WK_SCROLL_1ST;
                {PORT_SCROLL, 1'b1}: kind = WK_SCROLL_2ND;
                {PORT_ADDR,   1'b0}: kind = WK_ADDR_1ST;
                default:             kind = WK_ADDR_2ND;
            endcase
        end
    end
endmodule

// File: rtl/vreg_toggle.sv
module vreg_toggle
    import vreg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   status_rd,
    input  wkind_e kind,
    output logic   toggle
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst)
            tog_q <= 1'b0;
        else if (status_rd)
            tog_q <= 1'b0;
        else if (kind != WK_NONE)
            tog_q <= ~tog_q;
    end

    assign toggle = tog_q;

    a_r3_status_clears: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> !tog_q);
endmodule

// File: rtl/vreg_regs.sv
module vreg_regs
    import vreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wkind_e            kind,
    input  logic [DATA_W-1:0] data,
    output logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] tmp,
    output logic [FX_W-1:0]   fx
);
    logic [ADDR_W-1:0] cur_q, tmp_q;
    logic [FX_W-1:0]   fx_q;
    upd_t              upd;

    always_comb upd = apply_write(kind, tmp_q, fx_q, data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            tmp_q <= '0;
            fx_q  <= '0;
        end else begin
            tmp_q <= upd.tmp;
            fx_q  <= upd.fx;
            if (upd.commit)
                cur_q <= upd.tmp;
        end
    end

    assign cur = cur_q;
    assign tmp = tmp_q;
    assign fx  = fx_q;
endmodule

// File: rtl/vreg_port.sv
module vreg_port
    import vreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              status_rd,
    output logic [ADDR_W-1:0] vaddr_cur,
    output logic [ADDR_W-1:0] vaddr_tmp,
    output logic [FX_W-1:0]   fine_x,
    output logic              toggle
);
    wr_req_t req;
    wkind_e  kind;

    assign req.en   = wr_en;
    assign req.sel  = port_e'(wr_sel);
    assign req.data = wr_data;

    vreg_decode u_decode (
        .req       (req),
        .status_rd (status_rd),
        .toggle    (toggle),
        .kind      (kind)
    );

    vreg_toggle u_toggle (
        .clk       (clk),
        .rst       (rst),
        .status_rd (status_rd),
        .kind      (kind),
        .toggle    (toggle)
    );

    vreg_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .kind (kind),
        .data (wr_data),
        .cur  (vaddr_cur),
        .tmp  (vaddr_tmp),
        .fx   (fine_x)
    );

    // R2: an accepted write inverts the shared toggle
    a_r2_write_flips: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !status_rd) |=> (toggle != $past(toggle)));

    // R4: first scroll byte captures fine scroll
    a_r4_fine_capture: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !status_rd && !wr_sel && !toggle) |=> (fine_x == $past(wr_data[FX_W-1:0])));

    // R6: first address byte clears the top staging bit
    a_r6_top_cleared: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !status_rd && wr_sel && !toggle) |=> !vaddr_tmp[TOP_BIT]);

    // R7: second address byte commits the staging value
    a_r7_commit: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !status_rd && wr_sel && toggle) |=>
            (vaddr_cur == vaddr_tmp && vaddr_tmp[LO_W-1:0] == $past(wr_data)));

    // R8: live address holds unless a commit happens
    a_r8_cur_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && !status_rd && wr_sel && toggle) |=> $stable(vaddr_cur));

    // R9: a write during a status read leaves the address state untouched
    a_r9_collision: assert property (@(posedge clk) disable iff (rst)
        (wr_en && status_rd) |=> ($stable(vaddr_tmp) && $stable(vaddr_cur) && $stable(fine_x)));
endmodule

// File: tb/vreg_port_bench.sv
`timescale 1ns/100ps
module vreg_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        status_rd = 1'b0;
    logic [14:0] vaddr_cur, vaddr_tmp;
    logic [2:0]  fine_x;
    logic        toggle;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vreg_port u_vreg_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status_rd(status_rd), .vaddr_cur(vaddr_cur), .vaddr_tmp(vaddr_tmp),
        .fine_x(fine_x), .toggle(toggle)
    );

    typedef struct packed {
        logic        en;
        logic        sel;
        logic [7:0]  data;
        logic        st;
        logic [14:0] cur;
        logic [14:0] tmp;
        logic [2:0]  fx;
        logic        tog;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'hA5, 1'b0, 15'h0000, 15'h0014, 3'd5, 1'b1},
        '{1'b1, 1'b0, 8'h5E, 1'b0, 15'h0000, 15'h6174, 3'd5, 1'b0},
        '{1'b1, 1'b1, 8'hFF, 1'b0, 15'h0000, 15'h3F74, 3'd5, 1'b1},
        '{1'b1, 1'b1, 8'h12, 1'b0, 15'h3F12, 15'h3F12, 3'd5, 1'b0},
        '{1'b1, 1'b0, 8'h08, 1'b0, 15'h3F12, 15'h3F01, 3'd0, 1'b1},
        '{1'b1, 1'b1, 8'h21, 1'b0, 15'h3F21, 15'h3F21, 3'd0, 1'b0},
        '{1'b1, 1'b1, 8'h7A, 1'b0, 15'h3F21, 15'h3A21, 3'd0, 1'b1},
        '{1'b0, 1'b0, 8'h00, 1'b1, 15'h3F21, 15'h3A21, 3'd0, 1'b0},
        '{1'b1, 1'b1, 8'h05, 1'b0, 15'h3F21, 15'h0521, 3'd0, 1'b1},
        '{1'b1, 1'b0, 8'hFF, 1'b1, 15'h3F21, 15'h0521, 3'd0, 1'b0},
        '{1'b1, 1'b0, 8'hFF, 1'b0, 15'h3F21, 15'h053F, 3'd7, 1'b1},
        '{1'b0, 1'b1, 8'hAA, 1'b0, 15'h3F21, 15'h053F, 3'd7, 1'b1},
        '{1'b1, 1'b0, 8'h07, 1'b0, 15'h3F21, 15'h741F, 3'd7, 1'b0},
        '{1'b1, 1'b1, 8'h40, 1'b0, 15'h3F21, 15'h001F, 3'd7, 1'b1},
        '{1'b1, 1'b1, 8'hC3, 1'b0, 15'h00C3, 15'h00C3, 3'd7, 1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 4, 10: return "R4";
            1, 12:    return "R5";
            2, 6, 13: return "R6";
            3, 14:    return "R7";
            5:        return "R2";
            7, 8:     return "R3";
            9:        return "R9";
            default:  return "R8";
        endcase
    endfunction

    task automatic check_state(string tag, logic [14:0] ec, logic [14:0] et,
                               logic [2:0] ef, logic eg);
        checks++;
        if (vaddr_cur !== ec || vaddr_tmp !== et || fine_x !== ef || toggle !== eg) begin
            errors++;
            $display("FAIL %s: cur=%h tmp=%h fx=%0d tog=%b expected cur=%h tmp=%h fx=%0d tog=%b",
                     tag, vaddr_cur, vaddr_tmp, fine_x, toggle, ec, et, ef, eg);
        end
    endtask

    // Drive at the falling edge, release just after the rising edge
    task automatic drive(logic en, logic sel, logic [7:0] d, logic st);
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_data = d; status_rd = st;
        @(posedge clk);
        #1;
        wr_en = 1'b0; status_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_state("R1", 15'h0, 15'h0, 3'd0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].en, VECS[i].sel, VECS[i].data, VECS[i].st);
            check_state(tag_of(i), VECS[i].cur, VECS[i].tmp, VECS[i].fx, VECS[i].tog);
        end

        // R10: no change before the sampling edge, change right after it
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h11; status_rd = 1'b0;
        #2;
        check_state("R10", 15'h00C3, 15'h00C3, 3'd7, 1'b0);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check_state("R10", 15'h00C3, 15'h00C2, 3'd1, 1'b1);

        // R1: reset in the middle of a pair clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check_state("R1", 15'h0, 15'h0, 3'd0, 1'b0);

        // R2: after reset an address byte is a first write
        drive(1'b1, 1'b1, 8'hBF, 1'b0);
        check_state("R2", 15'h0, 15'h3F00, 3'd0, 1'b1);
        // R9: collision on the second byte does not commit
        drive(1'b1, 1'b1, 8'h99, 1'b1);
        check_state("R9", 15'h0, 15'h3F00, 3'd0, 1'b0);
        // R3: next address byte is again a first write
        drive(1'b1, 1'b1, 8'h01, 1'b0);
        check_state("R3", 15'h0, 15'h0100, 3'd0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule